// File: doc/BRIEF.md
# Multi-Range Address Matcher

This block holds a bank of host-programmed limit registers and tests one 32-bit probe value against every range they describe at once. Limits are grouped in pairs, and each pair forms one inclusive window. The result is a per-window hit mask, a flag that is set when any window hits, and the number of the lowest window that hits. Typical uses are address filtering, region attribute lookup and watchpoint units.

The host loads limits through a small memory-like port: it gives a register index, data and a write strobe. The register at the current index is always visible on a read-back bus. Each magnitude compare is split into 4-bit nibble slices. Each slice reports whether the probe is below, equal to or above the limit. A binary merge tree resolves the slices, with the most significant slice taking priority. One register stage holds the hit mask.

Top module: `range_matcher`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` into the limit register at index `lim_addr` (0..15) on the clock edge. `rd_data` always shows the register at the current `lim_addr`, with no clock delay.
- R2: Register 2r holds the lower limit and register 2r+1 holds the upper limit of range r (r = 0..7). Range r drives bit r of `hit`.
- R3: Range r hits when lower <= probe <= upper, unsigned. Both bounds are inclusive.
- R4: All eight ranges are evaluated in the same cycle, so several bits of `hit` can be set together.
- R5: `hit` reflects the probe value and the limit values present at the previous clock edge. A limit written at an edge first affects the result registered at the following edge.
- R6: `hit_any` is 1 exactly when at least one bit of `hit` is 1.
- R7: `hit_idx` is the number of the lowest set bit of `hit`, and 0 when no bit is set.
- R8: A range whose lower limit is greater than its upper limit never hits, whatever the probe value.
- R9: Active-low reset `rst_n` clears all sixteen limits to zero and clears `hit`.
- R10: The compare is exact over the full 32 bits. A probe that differs from a limit only in the most significant nibble, or only in the least significant nibble, is ordered correctly. The extremes 0 and 0xFFFFFFFF behave like any other value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the limit bank |
| lim_addr | input | 4 | Limit register index for writes and read-back |
| wr_data | input | 32 | Limit value to store |
| rd_data | output | 32 | Content of the limit register at `lim_addr` |
| probe | input | 32 | Value tested against all ranges |
| hit | output | 8 | Per-range match mask, bit r for range r |
| hit_any | output | 1 | High when any range matches |
| hit_idx | output | 3 | Lowest matching range number, 0 if none |

## Verification
Read-back is combinational, so after a write at one edge the new value is checked on `rd_data` in the next low clock phase. The match outputs sit one register behind the probe. The bench changes `probe` on a falling edge and compares `hit`, `hit_any` and `hit_idx` on the next falling edge, after exactly one rising edge has loaded them. For the write-versus-compare ordering, the bench issues a write and a new probe in the same cycle. It expects a result based on the old limits one falling edge later, and a result based on the new limits one cycle after that.

// File: rtl/range_matcher.sv
`timescale 1ns/1ps
module range_matcher #(
  parameter int NRANGE = 8,
  parameter int W      = 32,
  parameter int SLICE  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [$clog2(2*NRANGE)-1:0] lim_addr,
  input  logic [W-1:0]                wr_data,
  output logic [W-1:0]                rd_data,
  input  logic [W-1:0]                probe,
  output logic [NRANGE-1:0]           hit,
  output logic                        hit_any,
  output logic [$clog2(NRANGE)-1:0]   hit_idx
);
  // W/SLICE must be a power of two for the heap-ordered merge tree.
  localparam int NLIM  = 2 * NRANGE;
  localparam int IW    = $clog2(NRANGE);
  localparam int NSL   = W / SLICE;
  localparam int NNODE = 2 * NSL - 1;
  localparam logic [1:0] C_EQ = 2'b00;
  localparam logic [1:0] C_LT = 2'b01;
  localparam logic [1:0] C_GT = 2'b10;

  logic [NLIM-1:0][W-1:0] lim;
  logic [NLIM-1:0][1:0]   verdict;
  logic [NRANGE-1:0]      in_rng;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     lim <= '0;
    else if (wr_en) lim[lim_addr] <= wr_data;

  assign rd_data = lim[lim_addr];

  for (genvar l = 0; l < NLIM; l++) begin : g_lim
    logic [1:0] node [NNODE];
    for (genvar k = 0; k < NSL; k++) begin : g_leaf
      logic [SLICE-1:0] a, b;
      assign a = probe[W-1-k*SLICE -: SLICE];
      assign b = lim[l][W-1-k*SLICE -: SLICE];
      assign node[NSL-1+k] = (a < b) ? C_LT : (a > b) ? C_GT : C_EQ;
    end
    for (genvar i = 0; i < NSL - 1; i++) begin : g_merge
      assign node[i] = (node[2*i+1] != C_EQ) ? node[2*i+1] : node[2*i+2];
    end
    assign verdict[l] = node[0];
  end

  for (genvar r = 0; r < NRANGE; r++) begin : g_rng
    assign in_rng[r] = (verdict[2*r] != C_LT) && (verdict[2*r+1] != C_GT);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hit <= '0;
    else        hit <= in_rng;

  assign hit_any = |hit;

  always_comb begin
    hit_idx = '0;
    for (int i = NRANGE - 1; i >= 0; i--)
      if (hit[i]) hit_idx = IW'(i);
  end
endmodule

// File: rtl/range_matcher_chk.sv
`timescale 1ns/1ps
module range_matcher_chk #(
  parameter int NRANGE = 8,
  parameter int W      = 32
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            wr_en,
  input logic [$clog2(2*NRANGE)-1:0]     lim_addr,
  input logic [W-1:0]                    wr_data,
  input logic [W-1:0]                    rd_data,
  input logic [W-1:0]                    probe,
  input logic [2*NRANGE-1:0][W-1:0]      lim,
  input logic [NRANGE-1:0]               hit,
  input logic                            hit_any,
  input logic [$clog2(NRANGE)-1:0]       hit_idx
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  assert_wr_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(wr_en) && lim_addr == $past(lim_addr)) |-> rd_data == $past(wr_data));

  for (genvar r = 0; r < NRANGE; r++) begin : g_r
    // R2 pairing, R3 inclusive bounds, R5 one-cycle latency
    assert_range_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> hit[r] == ($past(probe) >= $past(lim[2*r]) && $past(probe) <= $past(lim[2*r+1])));
    assert_inverted_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(lim[2*r]) > $past(lim[2*r+1])) |-> !hit[r]);
  end

  assert_any_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> hit[hit_idx]);
  assert_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> ((hit & ((NRANGE'(1) << hit_idx) - NRANGE'(1))) == '0));
  assert_none_idx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_any |-> (hit_idx == '0 && hit == '0));
  assert_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (hit == '0 && rd_data == '0));
endmodule

bind range_matcher range_matcher_chk #(.NRANGE(NRANGE), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .lim_addr(lim_addr),
  .wr_data(wr_data), .rd_data(rd_data), .probe(probe), .lim(lim),
  .hit(hit), .hit_any(hit_any), .hit_idx(hit_idx)
);

// File: tb/sim_range_matcher.sv
`timescale 1ns/1ps
module sim_range_matcher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  lim_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [31:0] probe = '0;
  logic [7:0]  hit;
  logic        hit_any;
  logic [2:0]  hit_idx;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] model [16];

  always #5 clk = ~clk;

  range_matcher u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .lim_addr(lim_addr),
    .wr_data(wr_data), .rd_data(rd_data), .probe(probe),
    .hit(hit), .hit_any(hit_any), .hit_idx(hit_idx)
  );

  function automatic logic [7:0] exp_hit(logic [31:0] v);
    logic [7:0] e = '0;
    for (int r = 0; r < 8; r++)
      e[r] = (v >= model[2*r]) && (v <= model[2*r+1]);
    return e;
  endfunction

  function automatic logic [2:0] exp_idx(logic [7:0] h);
    logic [2:0] x = '0;
    for (int i = 7; i >= 0; i--) if (h[i]) x = 3'(i);
    return x;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; lim_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model[a] = d;
  endtask

  task automatic set_range(int r, logic [31:0] lo, logic [31:0] hi);
    wr(4'(2*r), lo);
    wr(4'(2*r+1), hi);
  endtask

  task automatic probe_chk(logic [31:0] v, string req);
    logic [7:0] e;
    @(negedge clk);
    probe = v;
    @(negedge clk);
    e = exp_hit(v);
    check({req, " hit"}, 32'(hit), 32'(e));
    check({req, " R6 any"}, 32'(hit_any), 32'(|e));
    check({req, " R7 idx"}, 32'(hit_idx), 32'(exp_idx(e)));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 hit in reset", 32'(hit), 32'h0);
    for (int a = 0; a < 16; a++) begin
      lim_addr = 4'(a);
      #1 check("R9 limit cleared", rd_data, 32'h0);
      model[a] = '0;
    end
    @(negedge clk);
    rst_n = 1'b1;
    probe_chk(32'h0, "R3 zero limits all hit");
  endtask

  task automatic t_readback;
    for (int a = 0; a < 16; a++) wr(4'(a), 32'hA5000000 ^ (32'(a) * 32'h01010101));
    for (int a = 0; a < 16; a++) begin
      lim_addr = 4'(a);
      #1 check("R1 readback", rd_data, 32'hA5000000 ^ (32'(a) * 32'h01010101));
    end
  endtask

  task automatic t_bounds;
    for (int r = 0; r < 8; r++) set_range(r, 32'hF0000000 + 32'(r*16), 32'hF0000000 + 32'(r*16 + 3));
    set_range(3, 32'h1000, 32'h1FFF);
    probe_chk(32'h0FFF, "R3 below lower");
    probe_chk(32'h1000, "R3 at lower R2");
    probe_chk(32'h1800, "R3 inside");
    probe_chk(32'h1FFF, "R3 at upper");
    probe_chk(32'h2000, "R3 above upper");
    probe_chk(32'hF0000072, "R2 range7");
  endtask

  task automatic t_overlap;
    set_range(0, 32'h100, 32'h1FF);
    set_range(1, 32'h180, 32'h2FF);
    set_range(2, 32'h0, 32'hFFFFFFFF);
    set_range(5, 32'h150, 32'h160);
    probe_chk(32'h155, "R4 three hits");
    check("R4 mask", 32'(hit), 32'h25);
    probe_chk(32'h250, "R4 two hits");
    probe_chk(32'h10, "R7 only range2");
    set_range(2, 32'h20, 32'h10);
    probe_chk(32'h10, "R8 inverted at upper");
    probe_chk(32'h18, "R8 inverted between");
    probe_chk(32'h20, "R8 inverted at lower");
    check("R6 none", 32'(hit_any), 32'h0);
  endtask

  task automatic t_slices;
    set_range(4, 32'h12345678, 32'h12345679);
    set_range(6, 32'h80000000, 32'hFFFFFFFF);
    set_range(7, 32'h0, 32'h0);
    probe_chk(32'h12345677, "R10 low nibble below");
    probe_chk(32'h12345678, "R10 exact lower");
    probe_chk(32'h12345679, "R10 exact upper");
    probe_chk(32'h1234567A, "R10 low nibble above");
    probe_chk(32'h02345678, "R10 top nibble below");
    probe_chk(32'h92345678, "R10 top nibble above");
    probe_chk(32'h7FFFFFFF, "R10 just below half");
    probe_chk(32'hFFFFFFFF, "R10 max value");
    probe_chk(32'h0, "R10 min value");
  endtask

  task automatic t_latency;
    logic [7:0] e_old, e_new;
    set_range(0, 32'h500, 32'h5FF);
    @(negedge clk);
    probe = 32'h700;
    e_old = exp_hit(32'h700);
    wr_en = 1'b1; lim_addr = 4'd1; wr_data = 32'h7FF;
    @(negedge clk);
    wr_en = 1'b0;
    model[1] = 32'h7FF;
    e_new = exp_hit(32'h700);
    check("R5 old limits used", 32'(hit), 32'(e_old));
    @(negedge clk);
    check("R5 new limit next", 32'(hit), 32'(e_new));
    probe = 32'h4FF;
    check("R5 hit holds until edge", 32'(hit), 32'(e_new));
    @(negedge clk);
    check("R5 probe change", 32'(hit), 32'(exp_hit(32'h4FF)));
  endtask

  task automatic t_sweep;
    logic [31:0] s = 32'hACE1_2345;
    for (int n = 0; n < 60; n++) begin
      s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
      if (n % 4 == 0) wr(s[3:0], s ^ 32'h5A5A0000);
      probe_chk(model[s[7:4]] + 32'(s[9:8]) - 32'd1, "R10 sweep");
    end
  endtask

  initial begin
    t_reset();
    t_readback();
    t_bounds();
    t_overlap();
    t_slices();
    t_latency();
    t_sweep();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule